// File: doc/BRIEF.md
# Clamp Bypass Window and Video Gate

This block sits at the output of a line-store video path. Once per line it opens a short window in which the undelayed input sample is passed on in place of the sample taken from the line store. An external clamp control loop measures the signal level during that window, so the loop does not see a one-line delay. The window start is set by a 4-bit position code in steps of 99 clocks. On the last line of the frame and on the first line the window is suppressed, and the delayed path is used for the whole line.

A blanking gate overrides both paths when enabled. On luma samples it drives black level (code 16). On chroma samples it drives the offset-binary zero (code 128). The caller provides the horizontal sample counter and the line number. A select input tells the block whether the current sample is luma or chroma.

Top module: `clamp_bypass_gate`

## Requirements
- R1: After reset `video_out` is 0, `bypass` is 0, and the latched position code is 1. If no line start (`h_cnt` = 0) occurs, the window opens at clock 99.
- R2: For latched position p, `bypass` is 1 for `h_cnt` in the range p*99 to p*99+15 inclusive, and 0 elsewhere. Both outputs are registered, so each one reflects the inputs of the previous clock.
- R3: While the window is open and the gate is off, `video_out` equals the `direct_in` value from the previous clock.
- R4: While the window is closed and the gate is off, `video_out` equals the `delayed_in` value from the previous clock.
- R5: On line 625 and on line 1 the window never opens, and the delayed path is used everywhere. On the other lines, such as 2 and 624, the window opens as usual.
- R6: With `gate_en` = 1 and `is_chroma` = 0, `video_out` is 16 one clock later.
- R7: With `gate_en` = 1 and `is_chroma` = 1, `video_out` is 128 one clock later.
- R8: The gate takes priority over the bypass window. `bypass` still reports the window while the gate is on.
- R9: `clamp_pos` is sampled only on a clock where `h_cnt` = 0, and that value applies to that clock as well. A change in the middle of a line takes effect at the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cnt | input | 11 | Sample index within the line, where 0 marks the line start |
| line_num | input | 10 | Current line number, starting at 1 |
| direct_in | input | 8 | Undelayed sample |
| delayed_in | input | 8 | Sample from the line store |
| clamp_pos | input | 4 | Window position code, in 99-clock steps |
| gate_en | input | 1 | Blanking gate enable |
| is_chroma | input | 1 | Current sample is chroma (1) or luma (0) |
| video_out | output | 8 | Selected and optionally gated sample |
| bypass | output | 1 | Window open for this output sample |

## Verification
The bench builds the block with its default parameters: 8-bit samples, an 11-bit horizontal counter, 99-clock steps and a 16-clock window. With these values every position code can be reached, including code 15, whose window starts at 1485. Table vectors check both window edges for several codes, the two suppressed lines and their neighbours, and the gate on luma, on chroma and inside the window. Directed steps then cover the reset state, the default position, and a position change in the middle of a line.

// File: rtl/clamp_bypass_gate.sv
module clamp_bypass_gate #(
  parameter int DATA_W      = 8,
  parameter int HCNT_W      = 11,
  parameter int LINE_W      = 10,
  parameter int STEP        = 99,
  parameter int BASE        = 0,
  parameter int WIN_LEN     = 16,
  parameter int LINE_LAST   = 625,
  parameter int LINE_FIRST  = 1,
  parameter int LUMA_BLACK  = 16,
  parameter int CHROMA_ZERO = 128,
  parameter int POS_RESET   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] h_cnt,
  input  logic [LINE_W-1:0] line_num,
  input  logic [DATA_W-1:0] direct_in,
  input  logic [DATA_W-1:0] delayed_in,
  input  logic [3:0]        clamp_pos,
  input  logic              gate_en,
  input  logic              is_chroma,
  output logic [DATA_W-1:0] video_out,
  output logic              bypass
);

  localparam int HW = HCNT_W + 1;

  logic [3:0]    pos_q;
  logic [3:0]    pos_eff;
  logic          line_start;
  logic          quiet_line;
  logic [HW-1:0] win_lo, win_hi, h_ext;
  logic          in_win;
  logic [DATA_W-1:0] sel, gated;

  assign line_start = (h_cnt == '0);
  assign pos_eff    = line_start ? clamp_pos : pos_q;
  assign quiet_line = (line_num == LINE_W'(LINE_LAST)) || (line_num == LINE_W'(LINE_FIRST));

  assign h_ext  = {1'b0, h_cnt};
  assign win_lo = HW'(BASE) + HW'(pos_eff) * HW'(STEP);
  assign win_hi = win_lo + HW'(WIN_LEN);
  assign in_win = !quiet_line && (h_ext >= win_lo) && (h_ext < win_hi);

  assign sel   = in_win ? direct_in : delayed_in;
  assign gated = is_chroma ? DATA_W'(CHROMA_ZERO) : DATA_W'(LUMA_BLACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= 4'(POS_RESET);
      video_out <= '0;
      bypass    <= 1'b0;
    end else begin
      if (line_start) pos_q <= clamp_pos;
      video_out <= gate_en ? gated : sel;
      bypass    <= in_win;
    end
  end

  assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |=> $stable(pos_q));

  assert_quiet_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num == LINE_W'(LINE_LAST) || line_num == LINE_W'(LINE_FIRST)) |=> !bypass);

  assert_gate_luma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !is_chroma) |=> (video_out == DATA_W'(LUMA_BLACK)));

  assert_gate_chroma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && is_chroma) |=> (video_out == DATA_W'(CHROMA_ZERO)));

  assert_quiet_delayed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && line_num == LINE_W'(LINE_FIRST)) |=> (video_out == $past(delayed_in)));

  assert_open_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !$past(gate_en)) |-> (video_out == $past(direct_in)));

endmodule

// File: tb/test_clamp_bypass_gate.sv
module test_clamp_bypass_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] h_cnt = '0;
  logic [9:0]  line_num = 10'd10;
  logic [7:0]  direct_in = '0, delayed_in = '0;
  logic [3:0]  clamp_pos = 4'd1;
  logic        gate_en = 1'b0, is_chroma = 1'b0;
  logic [7:0]  video_out;
  logic        bypass;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  clamp_bypass_gate i_clamp_bypass_gate (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_num(line_num),
    .direct_in(direct_in), .delayed_in(delayed_in), .clamp_pos(clamp_pos),
    .gate_en(gate_en), .is_chroma(is_chroma),
    .video_out(video_out), .bypass(bypass));

  typedef struct packed {
    logic [3:0]  req;
    logic [9:0]  line;
    logic [3:0]  pos;
    logic [10:0] h;
    logic        gate;
    logic        chroma;
    logic [7:0]  dir;
    logic [7:0]  del;
    logic [7:0]  eout;
    logic        ebyp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 10'd10,  4'd1,  11'd99,   1'b0, 1'b0, 8'hA1, 8'h5B, 8'hA1, 1'b1}, // R2 R3 lower edge
    '{4'd2, 10'd10,  4'd1,  11'd114,  1'b0, 1'b0, 8'hA2, 8'h5C, 8'hA2, 1'b1}, // R2 upper edge
    '{4'd4, 10'd10,  4'd1,  11'd115,  1'b0, 1'b0, 8'hA3, 8'h5D, 8'h5D, 1'b0}, // R4 just after
    '{4'd4, 10'd10,  4'd1,  11'd98,   1'b0, 1'b0, 8'hA4, 8'h5E, 8'h5E, 1'b0}, // R4 just before
    '{4'd2, 10'd20,  4'd0,  11'd0,    1'b0, 1'b1, 8'h33, 8'h44, 8'h33, 1'b1}, // R2 code 0
    '{4'd2, 10'd20,  4'd0,  11'd15,   1'b0, 1'b0, 8'h34, 8'h45, 8'h34, 1'b1}, // R2
    '{4'd4, 10'd20,  4'd0,  11'd16,   1'b0, 1'b0, 8'h35, 8'h46, 8'h46, 1'b0}, // R4
    '{4'd2, 10'd30,  4'd15, 11'd1485, 1'b0, 1'b0, 8'hE0, 8'h10, 8'hE0, 1'b1}, // R2 code 15
    '{4'd2, 10'd30,  4'd15, 11'd1500, 1'b0, 1'b0, 8'hE1, 8'h11, 8'hE1, 1'b1}, // R2
    '{4'd4, 10'd30,  4'd15, 11'd1501, 1'b0, 1'b0, 8'hE2, 8'h12, 8'h12, 1'b0}, // R4
    '{4'd4, 10'd30,  4'd15, 11'd1484, 1'b0, 1'b0, 8'hE3, 8'h13, 8'h13, 1'b0}, // R4
    '{4'd2, 10'd40,  4'd7,  11'd693,  1'b0, 1'b1, 8'h77, 8'h88, 8'h77, 1'b1}, // R2 code 7
    '{4'd4, 10'd40,  4'd7,  11'd692,  1'b0, 1'b1, 8'h78, 8'h89, 8'h89, 1'b0}, // R4
    '{4'd5, 10'd625, 4'd1,  11'd100,  1'b0, 1'b0, 8'h01, 8'hF1, 8'hF1, 1'b0}, // R5 last line
    '{4'd5, 10'd1,   4'd1,  11'd100,  1'b0, 1'b0, 8'h02, 8'hF2, 8'hF2, 1'b0}, // R5 first line
    '{4'd5, 10'd2,   4'd1,  11'd100,  1'b0, 1'b0, 8'h03, 8'hF3, 8'h03, 1'b1}, // R5 neighbour
    '{4'd5, 10'd624, 4'd1,  11'd100,  1'b0, 1'b0, 8'h04, 8'hF4, 8'h04, 1'b1}, // R5 neighbour
    '{4'd6, 10'd10,  4'd1,  11'd300,  1'b1, 1'b0, 8'h99, 8'h66, 8'd16, 1'b0}, // R6
    '{4'd7, 10'd10,  4'd1,  11'd300,  1'b1, 1'b1, 8'h99, 8'h66, 8'd128,1'b0}, // R7
    '{4'd8, 10'd10,  4'd1,  11'd100,  1'b1, 1'b0, 8'h99, 8'h66, 8'd16, 1'b1}, // R8 luma
    '{4'd8, 10'd10,  4'd1,  11'd100,  1'b1, 1'b1, 8'h99, 8'h66, 8'd128,1'b1}, // R8 chroma
    '{4'd7, 10'd625, 4'd1,  11'd100,  1'b1, 1'b1, 8'h99, 8'h66, 8'd128,1'b0}  // R7 quiet line
  };

  task automatic check(input string tag, input logic [7:0] eo, input logic eb);
    checks++;
    if (video_out !== eo || bypass !== eb) begin
      fails++;
      $display("FAIL %s: video_out=%0d bypass=%0b expected video_out=%0d bypass=%0b",
               tag, video_out, bypass, eo, eb);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    direct_in = 8'h55; delayed_in = 8'hAA;
    repeat (3) cyc();
    check("R1 reset", 8'd0, 1'b0);
    rst_n = 1'b1;
    // R1: default position 1 applies with no line start seen
    clamp_pos = 4'd5; h_cnt = 11'd99; line_num = 10'd10;
    direct_in = 8'h21; delayed_in = 8'h12;
    cyc();
    check("R1 default pos", 8'h21, 1'b1);

    for (int i = 0; i < NV; i++) begin
      line_num = VEC[i].line; clamp_pos = VEC[i].pos;
      h_cnt = '0; gate_en = 1'b0; is_chroma = 1'b0;
      cyc();
      h_cnt = VEC[i].h; gate_en = VEC[i].gate; is_chroma = VEC[i].chroma;
      direct_in = VEC[i].dir; delayed_in = VEC[i].del;
      cyc();
      checks++;
      if (video_out !== VEC[i].eout || bypass !== VEC[i].ebyp) begin
        fails++;
        $display("FAIL R%0d vector %0d: video_out=%0d bypass=%0b expected video_out=%0d bypass=%0b",
                 VEC[i].req, i, video_out, bypass, VEC[i].eout, VEC[i].ebyp);
      end
    end

    // R9: a mid-line change waits for the next line start
    gate_en = 1'b0; is_chroma = 1'b0; line_num = 10'd50;
    clamp_pos = 4'd3; h_cnt = '0;
    cyc();
    clamp_pos = 4'd6; h_cnt = 11'd297; direct_in = 8'h61; delayed_in = 8'h16;
    cyc();
    check("R9 old pos holds", 8'h61, 1'b1);
    h_cnt = 11'd594; direct_in = 8'h62; delayed_in = 8'h26;
    cyc();
    check("R9 new pos not yet", 8'h26, 1'b0);
    h_cnt = '0;
    cyc();
    h_cnt = 11'd594; direct_in = 8'h63; delayed_in = 8'h36;
    cyc();
    check("R9 new pos applied", 8'h63, 1'b1);
    h_cnt = 11'd297; direct_in = 8'h64; delayed_in = 8'h46;
    cyc();
    check("R9 old pos gone", 8'h46, 1'b0);

    // R1: reset again restores the default position
    rst_n = 1'b0;
    cyc();
    check("R1 reset again", 8'd0, 1'b0);
    rst_n = 1'b1; h_cnt = 11'd100; direct_in = 8'h71; delayed_in = 8'h17;
    cyc();
    check("R1 default after reset", 8'h71, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule